// File: doc/BRIEF.md
# Backlight Dimming Pulse-Width Modulator

This block drives one backlight enable pin with a pulse train whose frequency and duty are set by software through a small register port. A prescaler divides the system clock into ticks. A period counter steps once per tick and wraps after a programmed number of ticks. The output is high during the first part of each period, for a programmed number of ticks.

Prescaler, period and high-width writes land in pending copies. Software makes them live by setting a commit bit. While the modulator runs, a committed set is held back until the current period ends, so the output never shows a period built from mixed settings. While the modulator is stopped, a commit takes effect at once. A buffer-control field can switch the double buffering off. Configuration writes then reach the counters directly, at any point in the period. Reads always return the pending values.

Register map, 32-bit data, byte offsets:
- Run (0x00): bit 0 enable.
- Load (0x04): bit 0 commit.
- Setup A (0x08): prescaler in [25:16]; manual-source select in bit 1.
- Setup B (0x0C): period in [11:0]; high width in [28:16].
- Buffer control (0x10): bits [1:0].

Top module: `backlight_pwm`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `pwm_out` is low.
- R2: The period counter steps once every (prescaler + 1) clocks, where the prescaler is bits [25:16] of Setup A (0x08).
- R3: One output period lasts (period + 1) ticks, where the period is bits [11:0] of Setup B (0x0C).
- R4: `pwm_out` is high for the first min(high, period + 1) ticks of each period, where high is bits [28:16] of Setup B. A high width of 0 keeps the output low.
- R5: With bit 0 of Run (0x00) clear, `pwm_out` is low and both counters are held at 0. Setting the bit starts a fresh period at count 0 on the next clock.
- R6: With bit 1 of Setup A clear (manual source not selected), `pwm_out` stays low.
- R7: A write of 1 to bit 0 of Load (0x04) commits the pending settings only when the stored bit was 0. Writing 1 again while it is still 1 commits nothing.
- R8: A commit made while running takes effect at the next period boundary. The current period completes with the old settings.
- R9: A commit that arrives in the same clock as a period boundary governs the period that starts at that boundary.
- R10: A commit made while stopped takes effect at once.
- R11: With Buffer control (0x10) bits [1:0] both 1, the live settings follow the pending ones one clock after a write, at any point in the period. With only one of the two bits set, double buffering stays on.
- R12: Setup A and Setup B read back the pending values, even when they differ from the live ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset, for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Modulated backlight output |

## Verification
Two functions can fall on the same clock: a commit strobe and the period wrap. In that case the new settings must govern the period that begins at that wrap. To provoke this, the bench counts ticks from a known enable edge and issues the commit write in the cycle where the counter sits at its last value. It then counts the high samples of the following period and compares them against the newly committed width, not the old one. A second timing case checks that a commit landing mid-period leaves the rest of that period untouched. A third checks that bypass writes change the waveform partway through a period.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int PRE_W   = 10;
    localparam int PER_W   = 12;
    localparam int HI_W    = 13;
    localparam int BUF_W   = 2;

    localparam int PRE_LSB = 16;
    localparam int PER_LSB = 0;
    localparam int HI_LSB  = 16;
    localparam int SEL_BIT = 1;

    localparam logic [ADDR_W-1:0] OFS_RUN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SETA  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SETB  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_BUF   = 8'h10;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  high;
    } pwm_cfg_t;

    typedef struct packed {
        logic run;
        logic manual;
        logic bypass;
    } pwm_mode_t;

    function automatic logic [DATA_W-1:0] seta_word(input logic [PRE_W-1:0] pre,
                                                    input logic manual);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRE_LSB +: PRE_W] = pre;
        w[SEL_BIT] = manual;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] setb_word(input logic [PER_W-1:0] per,
                                                    input logic [HI_W-1:0] high);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PER_LSB +: PER_W] = per;
        w[HI_LSB +: HI_W] = high;
        return w;
    endfunction

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output pwm_cfg_t          shadow,
    output pwm_mode_t         mode,
    output logic              commit_pulse
);

    logic             run_q;
    logic             manual_q;
    logic [BUF_W-1:0] buf_q;
    logic             load_q;
    pwm_cfg_t         shadow_q;

    assign commit_pulse = we && (addr == OFS_LOAD) && wdata[0] && !load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            manual_q <= 1'b0;
            buf_q    <= '0;
            load_q   <= 1'b0;
            shadow_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_RUN:  run_q <= wdata[0];
                OFS_LOAD: load_q <= wdata[0];
                OFS_SETA: begin
                    shadow_q.pre <= wdata[PRE_LSB +: PRE_W];
                    manual_q     <= wdata[SEL_BIT];
                end
                OFS_SETB: begin
                    shadow_q.per  <= wdata[PER_LSB +: PER_W];
                    shadow_q.high <= wdata[HI_LSB +: HI_W];
                end
                OFS_BUF:  buf_q <= wdata[BUF_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_RUN:  rdata[0] = run_q;
            OFS_LOAD: rdata[0] = load_q;
            OFS_SETA: rdata = seta_word(shadow_q.pre, manual_q);
            OFS_SETB: rdata = setb_word(shadow_q.per, shadow_q.high);
            OFS_BUF:  rdata[BUF_W-1:0] = buf_q;
            default:  rdata = '0;
        endcase
    end

    assign shadow      = shadow_q;
    assign mode.run    = run_q;
    assign mode.manual = manual_q;
    assign mode.bypass = &buf_q;

    // R7: a commit leaves the stored bit set, so a repeat cannot pulse again
    p_commit_latch_r7: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> load_q);

endmodule

// File: rtl/bl_pwm_stage.sv
module bl_pwm_stage
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwm_cfg_t shadow,
    input  logic     commit_pulse,
    input  logic     bypass,
    input  logic     running,
    input  logic     wrap,
    output pwm_cfg_t active
);

    pwm_cfg_t staged_q;
    pwm_cfg_t active_q;
    logic     pending_q;
    logic     apply_ok;

    assign apply_ok = !running || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q  <= '0;
            active_q  <= '0;
            pending_q <= 1'b0;
        end else if (bypass) begin
            active_q  <= shadow;
            pending_q <= 1'b0;
        end else if (commit_pulse) begin
            staged_q <= shadow;
            if (apply_ok) begin
                active_q  <= shadow;
                pending_q <= 1'b0;
            end else begin
                pending_q <= 1'b1;
            end
        end else if (pending_q && apply_ok) begin
            active_q  <= staged_q;
            pending_q <= 1'b0;
        end
    end

    assign active = active_q;

    // R8: a commit in mid period is parked and leaves live settings alone
    p_defer_mid_period_r8: assert property (@(posedge clk) disable iff (rst)
        (!bypass && commit_pulse && running && !wrap) |=> (pending_q && $stable(active_q)));

    // R8: with nothing pending and no bypass, live settings do not move
    p_live_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !commit_pulse && !pending_q) |=> $stable(active_q));

    // R9: commit coinciding with the wrap is live for the new period
    p_commit_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (!bypass && commit_pulse && wrap) |=> (active_q == $past(shadow)));

endmodule

// File: rtl/bl_pwm_presc.sv
module bl_pwm_presc
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);

    logic [PRE_W-1:0] div_q;

    assign tick = running && (div_q >= pre);

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2: a non-zero divide never yields ticks on back-to-back clocks
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && pre != '0) |=> (!tick || pre == '0));

endmodule

// File: rtl/bl_pwm_wave.sv
module bl_pwm_wave
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     running,
    input  logic     manual,
    input  logic     tick,
    input  pwm_cfg_t active,
    output logic     wrap,
    output logic     wave
);

    localparam int CMP_W = ((HI_W > PER_W) ? HI_W : PER_W) + 1;

    logic [PER_W-1:0] pos_q;
    logic             at_end;

    assign at_end = (pos_q >= active.per);
    assign wrap   = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= at_end ? '0 : pos_q + 1'b1;
        end
    end

    assign wave = running && manual && (CMP_W'(pos_q) < CMP_W'(active.high));

    // R5: a stopped modulator keeps its period counter at zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !running |=> (pos_q == '0));

    // R5: every start begins at count zero
    p_fresh_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (pos_q == '0));

endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    pwm_cfg_t  shadow;
    pwm_cfg_t  active;
    pwm_mode_t mode;
    logic      commit_pulse;
    logic      tick;
    logic      wrap;

    bl_pwm_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .we           (bus_we),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .rdata        (bus_rdata),
        .shadow       (shadow),
        .mode         (mode),
        .commit_pulse (commit_pulse)
    );

    bl_pwm_stage u_stage (
        .clk          (clk),
        .rst          (rst),
        .shadow       (shadow),
        .commit_pulse (commit_pulse),
        .bypass       (mode.bypass),
        .running      (mode.run),
        .wrap         (wrap),
        .active       (active)
    );

    bl_pwm_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .running (mode.run),
        .pre     (active.pre),
        .tick    (tick)
    );

    bl_pwm_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .running (mode.run),
        .manual  (mode.manual),
        .tick    (tick),
        .active  (active),
        .wrap    (wrap),
        .wave    (pwm_out)
    );

endmodule

// File: tb/backlight_pwm_bench.sv
module backlight_pwm_bench;
    import bl_pwm_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    backlight_pwm u_backlight_pwm (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // {prescaler, period, high}
    localparam int NV = 7;
    localparam logic [34:0] VECS [0:NV-1] = '{
        {10'd0, 12'd9, 13'd3},
        {10'd0, 12'd9, 13'd0},
        {10'd0, 12'd9, 13'd10},
        {10'd0, 12'd9, 13'd200},
        {10'd2, 12'd3, 13'd2},
        {10'd1, 12'd4, 13'd5},
        {10'd3, 12'd2, 13'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller sits on a falling edge; returns one falling edge later
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    // stop, load settings with a commit, start; returns at count 0
    task automatic setup(input int pre, input int per, input int high);
        wr(OFS_RUN, 32'd0);
        wr(OFS_SETA, seta_word(PRE_W'(pre), 1'b1));
        wr(OFS_SETB, setb_word(PER_W'(per), HI_W'(high)));
        wr(OFS_LOAD, 32'd1);
        wr(OFS_LOAD, 32'd0);
        wr(OFS_RUN, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        int hi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 out", int'(pwm_out), 0);
        rd(OFS_RUN, v);  chk("R1 run", v, 0);
        rd(OFS_LOAD, v); chk("R1 load", v, 0);
        rd(OFS_SETA, v); chk("R1 setA", v, 0);
        rd(OFS_SETB, v); chk("R1 setB", v, 0);
        rd(OFS_BUF, v);  chk("R1 buf", v, 0);
        @(negedge clk);

        // R2 R3 R4 R10: vector table, commits made while stopped
        for (int k = 0; k < NV; k++) begin
            int pre, per, high, n, exp_hi;
            pre  = int'(VECS[k][34:25]);
            per  = int'(VECS[k][24:13]);
            high = int'(VECS[k][12:0]);
            n    = (per + 1) * (pre + 1);
            exp_hi = ((high < per + 1) ? high : per + 1) * (pre + 1);
            setup(pre, per, high);
            count_high(n, hi);
            chk("R2 R3 R4 R10 high clocks per period", hi, exp_hi);
            chk("R3 period restart level", int'(pwm_out), (high > 0) ? 1 : 0);
        end

        // R12: pending value read back while live one differs
        setup(0, 9, 3);
        wr(OFS_SETB, setb_word(12'd9, 13'd7));
        rd(OFS_SETB, v);
        chk("R12 setB readback", v, int'(setb_word(12'd9, 13'd7)));
        rd(OFS_SETA, v);
        chk("R12 setA readback", v, int'(seta_word(10'd0, 1'b1)));

        // R8: commit mid period, rest of period keeps old width
        setup(0, 9, 3);
        count_high(2, hi);
        wr(OFS_SETB, setb_word(12'd9, 13'd7));
        wr(OFS_LOAD, 32'd1);            // now at count 4
        count_high(6, hi);
        chk("R8 remainder of old period", hi, 0);
        count_high(10, hi);
        chk("R8 next period new width", hi, 7);
        wr(OFS_LOAD, 32'd0);

        // R9: commit in the same clock as the wrap
        setup(0, 9, 3);
        wr(OFS_SETB, setb_word(12'd9, 13'd6));   // now at count 1
        count_high(8, hi);                        // counts 1..8
        chk("R9 before wrap old width", hi, 2);
        chk("R9 last count low", int'(pwm_out), 0);
        wr(OFS_LOAD, 32'd1);                      // strobe while count is 9
        count_high(10, hi);
        chk("R9 period after wrap new width", hi, 6);
        wr(OFS_LOAD, 32'd0);

        // R7: second write of 1 without clearing commits nothing
        wr(OFS_RUN, 32'd0);
        wr(OFS_SETA, seta_word(10'd0, 1'b1));
        wr(OFS_SETB, setb_word(12'd9, 13'd3));
        wr(OFS_LOAD, 32'd1);
        wr(OFS_SETB, setb_word(12'd9, 13'd8));
        wr(OFS_LOAD, 32'd1);
        wr(OFS_RUN, 32'd1);
        count_high(10, hi);
        chk("R7 repeated commit ignored", hi, 3);
        wr(OFS_LOAD, 32'd0);

        // R11: full bypass changes width partway through a period
        setup(0, 9, 2);
        wr(OFS_BUF, 32'd3);                       // now at count 1
        count_high(3, hi);                        // counts 1..3
        wr(OFS_SETB, setb_word(12'd9, 13'd8));   // now at count 5
        chk("R11 bypass one clock after write", int'(pwm_out), 0);
        @(negedge clk);
        chk("R11 bypass live at count 6", int'(pwm_out), 1);
        wr(OFS_BUF, 32'd0);

        // R11: one buffer bit alone keeps double buffering
        wr(OFS_BUF, 32'd1);
        setup(0, 9, 2);
        count_high(4, hi);
        wr(OFS_SETB, setb_word(12'd9, 13'd8));
        @(negedge clk);
        chk("R11 partial bypass no effect", int'(pwm_out), 0);
        wr(OFS_BUF, 32'd0);

        // R5: stop mid period, then restart at count 0
        setup(0, 9, 3);
        count_high(5, hi);
        wr(OFS_RUN, 32'd0);
        chk("R5 stopped output low", int'(pwm_out), 0);
        count_high(3, hi);
        chk("R5 stays low while stopped", hi, 0);
        wr(OFS_RUN, 32'd1);
        chk("R5 restart high at count 0", int'(pwm_out), 1);
        count_high(4, hi);
        chk("R5 restart from count 0", hi, 3);

        // R6: manual source not selected keeps output low
        wr(OFS_SETA, seta_word(10'd0, 1'b0));
        count_high(10, hi);
        chk("R6 manual off output low", hi, 0);
        wr(OFS_SETA, seta_word(10'd0, 1'b1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule